// File: doc/BRIEF.md
# Embedded Video Timing Code Inserter

This block sits in a 10-bit video output path and turns a plain active-video pixel stream into a stream that carries its own timing. A four-word timing reference code is placed just before the first sample of every active run (start code), and another just after its last sample (end code). Each code is the word 0x3FF, two words of 0x000 and a status word. The status word carries the field flag, the vertical-blanking flag, a start/end flag and four parity bits that let a receiver correct single errors in those three flags.

Pixel data is delayed by five clock cycles so that the start code fits in front of the first sample without overwriting any sample. The field and vertical-blanking flags come from an external line/field counter. They are captured once, on the cycle a code begins, and held for all four of its words. Outside codes and active samples the output carries a blanking word taken from an input port. When two active runs are close together, a fixed slot rule decides which codes survive. Active samples always win, and a code is never cut short.

Top module: `sync_code_inserter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vid_out` takes the value of `blank_lvl` at that edge and `vid_ok` goes to 0. All pixel and strobe history held before the reset is discarded.
- R2: A pixel sampled with `act_in` high at edge E appears on `vid_out` after edge E+5 with `vid_ok` = 1. Active samples are never replaced by code or blanking words.
- R3: If `act_in` is sampled high at edge E, was low at edges E-1 to E-4, and no code slot conflicts (R10), the outputs after edges E+1 to E+4 are 0x3FF, 0x000, 0x000 and a status word with H (bit 6) = 0. `vid_ok` is 1 on all four words.
- R4: If `act_in` is sampled high at edge E and low at edges E+1 to E+4, the outputs after edges E+6 to E+9 are 0x3FF, 0x000, 0x000 and a status word with H (bit 6) = 1. `vid_ok` is 1 on all four words.
- R5: Status word bits: bit 9 = 1, bit 8 = field flag, bit 7 = vertical-blanking flag, bit 6 = H, bits 1..0 = 0.
- R6: Status word parity bits: bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H.
- R7: The F and V bits of a code are the values of `fld_in` and `vblk_in` sampled on the edge the code begins. For a start code this is the rising edge of `act_in`. For an end code it is the fourth edge after the first low sample. Changes to `fld_in` and `vblk_in` during the code have no effect on it.
- R8: Every output word that is neither an active sample nor a code word equals `blank_lvl` as sampled on the previous edge, with `vid_ok` = 0.
- R9: If an inactive gap is shorter than four samples, neither the end code of the earlier run nor the start code of the later run is emitted. The gap slots carry blanking.
- R10: A code occupies four output slots. A code that would begin while an earlier code still owns any of those slots is dropped whole. If an end code and a start code would begin on the same edge, the end code is kept. Gaps of four to seven samples therefore keep the end code and lose the start code.
- R11: With a gap of exactly eight samples, the start code follows the end code with no blanking word between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_in | input | 10 | Pixel word, meaningful while `act_in` is high |
| act_in | input | 1 | Active-video strobe |
| fld_in | input | 1 | Field flag from the line/field counter |
| vblk_in | input | 1 | Vertical-blanking flag from the line/field counter |
| blank_lvl | input | 10 | Word sent when neither data nor a code is due |
| vid_out | output | 10 | Multiplexed output stream |
| vid_ok | output | 1 | High on active samples and code words |

## Verification
The functions that compete for the same output slot are the end code of one active run and the start code of the next, with the delayed samples of both runs pressing in from either side. The bench provokes this with directed gaps of 1, 3, 4, 5, 7 and 8 samples, and with random runs whose gaps often fall below eight. It also varies the field and vertical-blanking flags on every cycle, so a flag captured at the wrong edge shows up in the status word. Each output slot is judged against a model in the bench that gives every code four reserved slots and applies the end-before-start and data-first rules. A missing, truncated or misplaced code therefore shows as a wrong word in a specific slot.

// File: rtl/sci_pkg.sv
// Shared constants, types and the status-word builder for the timing code
// inserter. Assumes a 10-bit word: the status word layout fills exactly ten bits.
package sci_pkg;

    localparam int PIX_W      = 10;
    localparam int CODE_WORDS = 4;
    localparam int IDX_W      = $clog2(CODE_WORDS);
    localparam int PIPE_DEPTH = CODE_WORDS + 1;

    typedef logic [PIX_W-1:0] word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        CODE_NONE = 2'd0,
        CODE_SAV  = 2'd1,
        CODE_EAV  = 2'd2
    } code_kind_t;

    localparam word_t WORD_ONES  = '1;
    localparam word_t WORD_ZEROS = '0;
    localparam idx_t  IDX_LAST   = idx_t'(CODE_WORDS - 1);

    // Status word: marker, flags, then parity bits that protect the flags.
    function automatic word_t status_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    // Word emitted at position idx of a code.
    function automatic word_t code_word(input code_kind_t kind, input idx_t idx,
                                        input logic f, input logic v);
        word_t w;
        if (idx == '0)
            w = WORD_ONES;
        else if (idx == IDX_LAST)
            w = status_word(f, v, kind == CODE_EAV);
        else
            w = WORD_ZEROS;
        return w;
    endfunction

endpackage

// File: rtl/sci_tap_line.sv
// Shift register that exposes every stage. Stage 0 holds the input from one
// edge ago and stage k the input from k+1 edges ago. Assumes a synchronous
// active-low reset clears every stage.
module sci_tap_line #(
    parameter int W     = 11,
    parameter int DEPTH = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              d,
    output logic [DEPTH-1:0][W-1:0]   taps
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_first
            // Capture the input word.
            always_ff @(posedge clk) begin
                if (!rst_n) taps[0] <= '0;
                else        taps[0] <= d;
            end
        end else begin : g_next
            // Move the word one stage deeper.
            always_ff @(posedge clk) begin
                if (!rst_n) taps[k] <= '0;
                else        taps[k] <= taps[k-1];
            end
        end
    end

endmodule

// File: rtl/sci_req_detect.sv
// Decides on each edge whether a start code or an end code may begin, using
// the strobe history. A start needs the strobe low for CODE_WORDS samples
// before the rise. An end needs CODE_WORDS low samples after the fall, which
// are all visible by the time the last active sample reaches the tail tap.
module sci_req_detect
    import sci_pkg::*;
(
    input  logic                   act_in,
    input  logic [PIPE_DEPTH-1:0]  act_hist,
    output logic                   sav_req,
    output logic                   eav_req
);

    logic quiet_recent;

    // Flag a run of low strobe samples in the most recent history.
    always_comb begin
        quiet_recent = ~|act_hist[CODE_WORDS-1:0];
        sav_req      = act_in & quiet_recent;
        eav_req      = act_hist[CODE_WORDS] & quiet_recent;
    end

endmodule

// File: rtl/sci_sequencer.sv
// Steps through the four words of a timing code. Codes are atomic: a new code
// may begin only when idle or on the last word of the current one. An end
// request beats a start request on the same edge. The field and vertical
// flags are captured when a code begins.
module sci_sequencer
    import sci_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sav_req,
    input  logic        eav_req,
    input  logic        fld_in,
    input  logic        vblk_in,
    output code_kind_t  kind,
    output idx_t        idx,
    output logic        f_hold,
    output logic        v_hold
);

    logic slot_free;
    logic on_last;

    // Find out whether the four-slot window for a new code is open.
    always_comb begin
        on_last   = (idx == IDX_LAST);
        slot_free = (kind == CODE_NONE) || on_last;
    end

    // Start, advance or retire the code in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind   <= CODE_NONE;
            idx    <= '0;
            f_hold <= 1'b0;
            v_hold <= 1'b0;
        end else if (slot_free && (eav_req || sav_req)) begin
            kind   <= eav_req ? CODE_EAV : CODE_SAV;
            idx    <= '0;
            f_hold <= fld_in;
            v_hold <= vblk_in;
        end else if (kind != CODE_NONE) begin
            if (on_last) kind <= CODE_NONE;
            else         idx  <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/sci_out_stage.sv
// Output multiplexer and register. Delayed active data has priority, then the
// current code word, then the blanking word. Assumes the sequencer never
// schedules a code over delayed active data.
module sci_out_stage
    import sci_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_sel,
    input  word_t       data_word,
    input  code_kind_t  kind,
    input  idx_t        idx,
    input  logic        f_hold,
    input  logic        v_hold,
    input  word_t       blank_lvl,
    output word_t       vid_out,
    output logic        vid_ok
);

    word_t nxt_word;
    logic  nxt_ok;

    // Pick the source of the next output word.
    always_comb begin
        if (data_sel) begin
            nxt_word = data_word;
            nxt_ok   = 1'b1;
        end else if (kind != CODE_NONE) begin
            nxt_word = code_word(kind, idx, f_hold, v_hold);
            nxt_ok   = 1'b1;
        end else begin
            nxt_word = blank_lvl;
            nxt_ok   = 1'b0;
        end
    end

    // Register the output; reset drives blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_out <= blank_lvl;
            vid_ok  <= 1'b0;
        end else begin
            vid_out <= nxt_word;
            vid_ok  <= nxt_ok;
        end
    end

endmodule

// File: rtl/sync_code_inserter.sv
// Top level of the timing code inserter. Delays strobe and pixel together so
// a start code fits before the first sample. Edge requests are derived from
// the strobe history and fed to the code sequencer, and the output stage
// merges the three sources. Assumes fld_in and vblk_in are synchronous to clk.
module sync_code_inserter
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              act_in,
    input  logic              fld_in,
    input  logic              vblk_in,
    input  logic [PIX_W-1:0]  blank_lvl,
    output logic [PIX_W-1:0]  vid_out,
    output logic              vid_ok
);

    localparam int LINE_W = PIX_W + 1;

    logic [PIPE_DEPTH-1:0][LINE_W-1:0] line_taps;
    logic [PIPE_DEPTH-1:0]             act_hist;
    logic                              tail_act;
    word_t                             tail_pix;
    logic                              sav_req;
    logic                              eav_req;
    code_kind_t                        seq_kind;
    idx_t                              seq_idx;
    logic                              f_hold;
    logic                              v_hold;

    sci_tap_line #(
        .W     (LINE_W),
        .DEPTH (PIPE_DEPTH)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({act_in, pix_in}),
        .taps  (line_taps)
    );

    for (genvar k = 0; k < PIPE_DEPTH; k++) begin : g_act
        assign act_hist[k] = line_taps[k][PIX_W];
    end

    assign tail_act = line_taps[PIPE_DEPTH-1][PIX_W];
    assign tail_pix = line_taps[PIPE_DEPTH-1][PIX_W-1:0];

    sci_req_detect u_req (
        .act_in   (act_in),
        .act_hist (act_hist),
        .sav_req  (sav_req),
        .eav_req  (eav_req)
    );

    sci_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sav_req (sav_req),
        .eav_req (eav_req),
        .fld_in  (fld_in),
        .vblk_in (vblk_in),
        .kind    (seq_kind),
        .idx     (seq_idx),
        .f_hold  (f_hold),
        .v_hold  (v_hold)
    );

    sci_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_sel  (tail_act),
        .data_word (tail_pix),
        .kind      (seq_kind),
        .idx       (seq_idx),
        .f_hold    (f_hold),
        .v_hold    (v_hold),
        .blank_lvl (blank_lvl),
        .vid_out   (vid_out),
        .vid_ok    (vid_ok)
    );

endmodule

// File: rtl/sci_inserter_chk.sv
// Property checker for the timing code inserter, attached by bind. Relates
// the sequencer state and the delayed strobe to the registered output.
module sci_inserter_chk
    import sci_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        act_in,
    input  word_t       pix_in,
    input  word_t       blank_lvl,
    input  word_t       vid_out,
    input  logic        vid_ok,
    input  code_kind_t  kind,
    input  idx_t        idx,
    input  logic        tail_act
);

    // R1: reset forces the blanking word and drops the qualifier.
    assert_reset_blank_R1: assert property (@(posedge clk)
        !rst_n |=> (!vid_ok && vid_out == $past(blank_lvl)));

    // R2: an active sample leaves five edges after it was taken.
    assert_pixel_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4)
         && $past(rst_n, 5) && $past(rst_n, 6) && $past(act_in, 6))
        |-> (vid_ok && vid_out == $past(pix_in, 6)));

    // R3: every code opens with the all-ones word.
    assert_code_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CODE_NONE && idx == '0) |=> (vid_ok && vid_out == WORD_ONES));

    // R3: a start code carries H = 0 and is followed by active data.
    assert_sav_then_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CODE_SAV && idx == IDX_LAST) |=> (!vid_out[6] ##1 vid_ok));

    // R4: an end code carries H = 1.
    assert_eav_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CODE_EAV && idx == IDX_LAST) |=> vid_out[6]);

    // R5 and R6: fixed status bits and parity agree with the flags.
    assert_status_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CODE_NONE && idx == IDX_LAST) |=>
        (vid_out[9] && vid_out[1:0] == 2'b00
         && vid_out[5] == (vid_out[7] ^ vid_out[6])
         && vid_out[4] == (vid_out[8] ^ vid_out[6])
         && vid_out[3] == (vid_out[8] ^ vid_out[7])
         && vid_out[2] == (vid_out[8] ^ vid_out[7] ^ vid_out[6])));

    // R8: with no data and no code the output is blanking.
    assert_blank_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CODE_NONE && !tail_act) |=> (!vid_ok && vid_out == $past(blank_lvl)));

endmodule

bind sync_code_inserter sci_inserter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_in    (act_in),
    .pix_in    (pix_in),
    .blank_lvl (blank_lvl),
    .vid_out   (vid_out),
    .vid_ok    (vid_ok),
    .kind      (seq_kind),
    .idx       (seq_idx),
    .tail_act  (tail_act)
);

// File: tb/test_sync_code_inserter.sv
module test_sync_code_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int HN  = 8192;
    localparam int OFS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] pix_in = '0;
    logic       act_in = 1'b0;
    logic       fld_in = 1'b0;
    logic       vblk_in = 1'b0;
    logic [9:0] blank_lvl = 10'h040;
    logic [9:0] vid_out;
    logic       vid_ok;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int last_start = -100;
    int last_kind = 0;

    logic       act_h  [HN];
    logic [9:0] pix_h  [HN];
    logic       fld_h  [HN];
    logic       vblk_h [HN];
    logic [9:0] blk_h  [HN];
    int         kind_h [HN];
    logic       fs_h   [HN];
    logic       vs_h   [HN];
    logic       r11_h  [HN];
    int         tag_h  [HN];

    sync_code_inserter i_sync_code_inserter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_in    (pix_in),
        .act_in    (act_in),
        .fld_in    (fld_in),
        .vblk_in   (vblk_in),
        .blank_lvl (blank_lvl),
        .vid_out   (vid_out),
        .vid_ok    (vid_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic A(input int i);
        if (i < 0) return 1'b0;
        return act_h[i + OFS];
    endfunction

    // Status word as required by R5 and R6.
    function automatic logic [9:0] exp_status(input logic f, input logic v, input logic h);
        logic [9:0] w;
        w[9] = 1'b1; w[8] = f; w[7] = v; w[6] = h;
        w[5] = v ^ h; w[4] = f ^ h; w[3] = f ^ v; w[2] = f ^ v ^ h;
        w[1:0] = 2'b00;
        return w;
    endfunction

    task automatic mark(input int e, input int code);
        for (int i = 1; i <= 4; i++) tag_h[e + i + OFS] = code;
    endtask

    task automatic begin_code(input int e, input int k);
        kind_h[e + OFS] = k;
        fs_h[e + OFS]   = fld_h[e + OFS];
        vs_h[e + OFS]   = vblk_h[e + OFS];
        last_start = e;
        last_kind  = k;
    endtask

    // Slot model: each code reserves four output slots; end before start.
    task automatic model_edge(input int e);
        logic fall, rise;
        fall = A(e - 5) && !A(e - 4);
        rise = A(e) && !A(e - 1);
        if (fall) begin
            if (A(e - 3) || A(e - 2) || A(e - 1)) mark(e, 9);
            else if (e - last_start >= 4) begin_code(e, 2);
            else mark(e, 10);
        end
        if (rise) begin
            if (A(e - 4) || A(e - 3) || A(e - 2)) mark(e, 9);
            else if (e - last_start < 4) mark(e, 10);
            else begin
                if (e - last_start == 4 && last_kind == 2) r11_h[e + OFS] = 1'b1;
                begin_code(e, 1);
            end
        end
    endtask

    task automatic compare(input logic [10:0] act, input logic [10:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge %0d: actual ok=%0b word=%h expected ok=%0b word=%h",
                     tag, n, act[10], act[9:0], exp[10], exp[9:0]);
        end
    endtask

    task automatic check_edge(input int e);
        logic [9:0] ew;
        logic       eok;
        string      tag;
        int         s_hit;
        s_hit = -1;
        if (A(e - 5)) begin
            ew = pix_h[e - 5 + OFS]; eok = 1'b1; tag = "R2";
        end else begin
            for (int s = e - 4; s <= e - 1; s++)
                if (s >= 0 && kind_h[s + OFS] != 0) s_hit = s;
            if (s_hit >= 0) begin
                int k;
                k   = e - 1 - s_hit;
                eok = 1'b1;
                tag = (kind_h[s_hit + OFS] == 1) ? "R3" : "R4";
                if (k == 0)      ew = 10'h3FF;
                else if (k == 3) begin
                    ew  = exp_status(fs_h[s_hit + OFS], vs_h[s_hit + OFS], kind_h[s_hit + OFS] == 2);
                    tag = {tag, " R5 R6 R7"};
                end else         ew = 10'h000;
                if (r11_h[s_hit + OFS]) tag = {tag, " R11"};
            end else begin
                ew  = blk_h[e + OFS];
                eok = 1'b0;
                if (tag_h[e + OFS] == 9)       tag = "R8 R9";
                else if (tag_h[e + OFS] == 10) tag = "R8 R10";
                else                           tag = "R8";
            end
        end
        compare({vid_ok, vid_out}, {eok, ew}, tag);
    endtask

    // Drive one cycle of stimulus, record it, then judge the output.
    task automatic step(input logic a, input logic [9:0] p, input logic f,
                        input logic v, input logic [9:0] b);
        if (n + OFS + 12 >= HN) return;
        act_h[n + OFS] = a; pix_h[n + OFS] = p; fld_h[n + OFS] = f;
        vblk_h[n + OFS] = v; blk_h[n + OFS] = b;
        act_in = a; pix_in = p; fld_in = f; vblk_in = v; blank_lvl = b;
        @(posedge clk);
        model_edge(n);
        @(negedge clk);
        check_edge(n);
        n++;
    endtask

    // One active run followed by an inactive gap; flags toggle in the gap (R7).
    task automatic burst(input int len, input int gap, input logic f, input logic v);
        for (int i = 0; i < len; i++) step(1'b1, 10'($urandom), f, v, blank_lvl);
        for (int i = 0; i < gap; i++) step(1'b0, 10'($urandom), f ^ i[0], v ^ i[1], blank_lvl);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished run");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < HN; i++) begin
            act_h[i] = 0; pix_h[i] = 0; fld_h[i] = 0; vblk_h[i] = 0; blk_h[i] = 0;
            kind_h[i] = 0; fs_h[i] = 0; vs_h[i] = 0; r11_h[i] = 0; tag_h[i] = 0;
        end
        // R1: reset with a busy strobe; output must follow the blanking port.
        act_in = 1'b1; pix_in = 10'h155; fld_in = 1'b1; vblk_in = 1'b1;
        blank_lvl = 10'h040;
        @(posedge clk);
        @(negedge clk);
        compare({vid_ok, vid_out}, {1'b0, 10'h040}, "R1");
        blank_lvl = 10'h200;
        @(posedge clk);
        @(negedge clk);
        compare({vid_ok, vid_out}, {1'b0, 10'h200}, "R1");
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare({vid_ok, vid_out}, {1'b0, 10'h200}, "R1");
        rst_n = 1'b1;
        blank_lvl = 10'h040;

        // Directed corner cases.
        for (int i = 0; i < 6; i++) step(1'b0, 10'h0, 1'b0, 1'b0, 10'h040);
        burst(6, 10, 1'b0, 1'b0);
        burst(1, 8, 1'b1, 1'b0);   // R11: exact eight-sample gap
        burst(3, 5, 1'b0, 1'b1);   // R10
        burst(2, 4, 1'b1, 1'b1);   // R10: end and start on the same edge
        burst(2, 7, 1'b0, 1'b0);   // R10
        burst(2, 3, 1'b1, 1'b0);   // R9
        burst(2, 1, 1'b0, 1'b1);   // R9
        burst(4, 12, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 10'h0, 1'b0, 1'b0, 10'($urandom)); // R8
        burst(5, 9, 1'b1, 1'b0);

        // Constrained random runs and gaps.
        for (int b = 0; b < 150; b++) begin
            int len, gap;
            len = 1 + int'($urandom % 16);
            gap = ($urandom % 2 == 0) ? 1 + int'($urandom % 9) : 8 + int'($urandom % 20);
            for (int i = 0; i < len; i++)
                step(1'b1, 10'($urandom), 1'($urandom), 1'($urandom), blank_lvl);
            for (int i = 0; i < gap; i++)
                step(1'b0, 10'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom % 8 == 0) ? 10'($urandom) : blank_lvl);
        end
        for (int i = 0; i < 20; i++) step(1'b0, 10'h0, 1'b0, 1'b0, 10'h040);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule